// File: doc/BRIEF.md
# Vector Register Group Element Access

This block holds a file of 32 vector registers, each `VLEN` bits wide, and gives access to one element at a time anywhere inside a register group. A request names an element width, a signed group-size exponent, the first register of the group and an element index. The block splits the index into a register-within-group number and a position inside that register. It turns the position into a bit offset, then reads that slice or replaces it with new data.

The same request is also checked for legality. The group must fit below register 32 and must start on a multiple of its own size. The element must lie inside the group, and the element width must not be wider than a register. An illegal request raises `group_error`, reads as zero and writes nothing. Reads are combinational from the register array. A legal write takes effect at the next rising clock edge. A synchronous active-high reset clears every register.

Top module: `vgrp_elem_access`

## Requirements
- R1: A read returns, zero-extended to 64 bits, the element held in bits [off+W-1:off] of register vrid + index/(VLEN/W), where W is the element width (eew code 0, 1, 2 and 3 select 8, 16, 32 and 64 bits), off = (index mod (VLEN/W))*W, and element 0 of a register sits in its least significant bits.
- R2: lmul_pow is a 3-bit two's complement exponent; the group spans 2^lmul_pow registers when it is non-negative, and exactly one whole register when it is negative.
- R3: group_error is high when vrid plus the group size exceeds 32.
- R4: group_error is high when vrid is not a multiple of the group size.
- R5: group_error is high when index/(VLEN/W) is not below the group size, that is, when the element lies outside the group.
- R6: group_error is high when the element width exceeds VLEN.
- R7: When we is high and group_error is low, the addressed W-bit slice takes the low W bits of wdata at the rising clock edge, and every other bit of that register keeps its value.
- R8: While group_error is high, rdata is zero and no register changes, even with we high.
- R9: A synchronous reset clears all 32 registers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write the addressed element at the next edge |
| eew | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| lmul_pow | input | 3 | Signed group-size exponent |
| vrid | input | 5 | First register of the group |
| index | input | $clog2(VLEN)+1 | Element index within the group |
| wdata | input | 64 | Write data, low W bits used |
| rdata | output | 64 | Addressed element, zero-extended |
| group_error | output | 1 | Request addresses an illegal group or element |

## Verification
The read-back property assumes that the request fields stay the same across the cycle that follows a write, so that the same element is addressed before and after the edge. The reset property assumes that no legal write is committed on the edge where reset is released. The bench holds every request steady between falling edges and only ever writes from a falling edge after reset has dropped, so both assumptions hold. The illegal-request properties relate the error flag to vrid, lmul_pow and eew alone, and hold for any input. The sweep therefore drives every combination of width, exponent and base register, including unaligned and overflowing ones.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;

  localparam int unsigned NUM_VREGS  = 32;
  localparam int unsigned VREG_AW    = 5;
  localparam int unsigned ELEM_MAX_W = 64;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_code_e;

  // log2 of the element width in bits for a width code
  function automatic logic [3:0] ew_log2(input logic [1:0] code);
    return 4'd3 + 4'(code);
  endfunction

endpackage

// File: rtl/vgrp_addr_calc.sv
module vgrp_addr_calc
  import vgrp_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int IDX_W = $clog2(VLEN) + 1,
  parameter int OFF_W = $clog2(VLEN)
) (
  input  logic [1:0]         eew,
  input  logic [2:0]         lmul_pow,
  input  logic [4:0]         vrid,
  input  logic [IDX_W-1:0]   index,
  output logic               bad,
  output logic [4:0]         preg,
  output logic [OFF_W-1:0]   bit_off
);

  localparam int VLEN_LOG2 = $clog2(VLEN);

  logic [1:0]       lp;
  logic [3:0]       grp_sz;
  logic [3:0]       wlog;
  logic             ew_big;
  int               epr_log2;
  logic [IDX_W-1:0] rig;
  logic [IDX_W-1:0] pos;
  logic [5:0]       span_end;
  logic             overflow;
  logic             misalign;
  logic             outside;

  always_comb begin
    // negative exponent collapses to one register
    lp       = lmul_pow[2] ? 2'd0 : lmul_pow[1:0];
    grp_sz   = 4'd1 << lp;
    wlog     = ew_log2(eew);
    ew_big   = (int'(wlog) > VLEN_LOG2);
    epr_log2 = ew_big ? 0 : (VLEN_LOG2 - int'(wlog));
    rig      = index >> epr_log2;
    pos      = index & IDX_W'((1 << epr_log2) - 1);
    bit_off  = OFF_W'(pos) << wlog;
    span_end = 6'(vrid) + 6'(grp_sz);
    overflow = (span_end > 6'd32);
    misalign = ((vrid & 5'(grp_sz - 4'd1)) != 5'd0);
    outside  = (rig >= IDX_W'(grp_sz));
    preg     = vrid + 5'(rig);
    bad      = ew_big | overflow | misalign | outside;
  end

endmodule

// File: rtl/vgrp_slice_unit.sv
module vgrp_slice_unit
  import vgrp_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int DW    = ELEM_MAX_W,
  parameter int OFF_W = $clog2(VLEN)
) (
  input  logic [VLEN-1:0]  row,
  input  logic [1:0]       eew,
  input  logic [OFF_W-1:0] bit_off,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    elem,
  output logic [VLEN-1:0]  merged
);

  logic [DW-1:0]   emask;
  logic [VLEN-1:0] row_mask;
  logic [VLEN-1:0] ins;

  always_comb begin
    emask    = {DW{1'b1}} >> (DW - (8 << eew));
    row_mask = VLEN'(emask) << bit_off;
    ins      = VLEN'(wdata & emask) << bit_off;
    elem     = DW'(row >> bit_off) & emask;
    merged   = (row & ~row_mask) | ins;
  end

endmodule

// File: rtl/vgrp_regfile.sv
module vgrp_regfile
  import vgrp_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int NREG = NUM_VREGS,
  parameter int AW   = VREG_AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wen,
  input  logic [AW-1:0]   addr,
  input  logic [VLEN-1:0] wrow,
  output logic [VLEN-1:0] rrow
);

  logic [VLEN-1:0] row_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        row_q[g] <= '0;
      end else if (wen && (addr == AW'(g))) begin
        row_q[g] <= wrow;
      end
    end
  end

  assign rrow = row_q[addr];

endmodule

// File: rtl/vgrp_elem_access.sv
module vgrp_elem_access
  import vgrp_pkg::*;
#(
  parameter  int VLEN  = 128,
  parameter  int DW    = ELEM_MAX_W,
  localparam int IDX_W = $clog2(VLEN) + 1,
  localparam int OFF_W = $clog2(VLEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       eew,
  input  logic [2:0]       lmul_pow,
  input  logic [4:0]       vrid,
  input  logic [IDX_W-1:0] index,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             group_error
);

  logic             bad;
  logic [4:0]       preg;
  logic [OFF_W-1:0] bit_off;
  logic [VLEN-1:0]  row;
  logic [VLEN-1:0]  merged;
  logic [DW-1:0]    elem;

  vgrp_addr_calc #(.VLEN(VLEN), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .eew(eew), .lmul_pow(lmul_pow), .vrid(vrid), .index(index),
    .bad(bad), .preg(preg), .bit_off(bit_off)
  );

  vgrp_regfile #(.VLEN(VLEN), .NREG(NUM_VREGS), .AW(VREG_AW)) u_rf (
    .clk(clk), .rst(rst), .wen(we & ~bad), .addr(preg),
    .wrow(merged), .rrow(row)
  );

  vgrp_slice_unit #(.VLEN(VLEN), .DW(DW), .OFF_W(OFF_W)) u_slice (
    .row(row), .eew(eew), .bit_off(bit_off), .wdata(wdata),
    .elem(elem), .merged(merged)
  );

  assign rdata       = bad ? '0 : elem;
  assign group_error = bad;

endmodule

// File: rtl/vgrp_elem_access_chk.sv
module vgrp_elem_access_chk #(
  parameter int VLEN  = 128,
  parameter int DW    = 64,
  parameter int IDX_W = $clog2(VLEN) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             we,
  input logic [1:0]       eew,
  input logic [2:0]       lmul_pow,
  input logic [4:0]       vrid,
  input logic [IDX_W-1:0] index,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic             group_error
);

  logic [3:0]    gsz;
  logic [DW-1:0] wmask;

  always_comb begin
    gsz   = lmul_pow[2] ? 4'd1 : (4'd1 << lmul_pow[1:0]);
    wmask = {DW{1'b1}} >> (DW - (8 << eew));
  end

  a_r8_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
    group_error |-> (rdata == '0));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ((6'(vrid) + 6'(gsz)) > 6'd32) |-> group_error);

  a_r4_aligned_base: assert property (@(posedge clk) disable iff (rst)
    ((vrid & 5'(gsz - 4'd1)) != 5'd0) |-> group_error);

  a_r6_width_fits: assert property (@(posedge clk) disable iff (rst)
    ((8 << eew) > VLEN) |-> group_error);

  a_r7_readback: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we) && !$past(group_error) && $stable(eew) &&
     $stable(lmul_pow) && $stable(vrid) && $stable(index))
    |-> (rdata == ($past(wdata) & wmask)));

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !group_error) |-> (rdata == '0));

endmodule

bind vgrp_elem_access vgrp_elem_access_chk #(
  .VLEN(VLEN), .DW(DW), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .we(we), .eew(eew), .lmul_pow(lmul_pow),
  .vrid(vrid), .index(index), .wdata(wdata), .rdata(rdata),
  .group_error(group_error)
);

// File: tb/vgrp_elem_access_test.sv
`timescale 1ns/1ps
module vgrp_elem_access_test;

  localparam int VL  = 128;
  localparam int IW  = $clog2(VL) + 1;
  localparam int VLS = 32;
  localparam int IWS = $clog2(VLS) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic [1:0]    eew = '0;
  logic [2:0]    lmul_pow = '0;
  logic [4:0]    vrid = '0;
  logic [IW-1:0] index = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic          group_error;

  logic [1:0]     s_eew = '0;
  logic [IWS-1:0] s_index = '0;
  logic [63:0]    s_rdata;
  logic           s_err;

  int checks = 0;
  int errors = 0;
  logic [VL-1:0] model [32];

  always #2.5 clk = ~clk;

  vgrp_elem_access #(.VLEN(VL)) uut (
    .clk(clk), .rst(rst), .we(we), .eew(eew), .lmul_pow(lmul_pow),
    .vrid(vrid), .index(index), .wdata(wdata), .rdata(rdata),
    .group_error(group_error)
  );

  vgrp_elem_access #(.VLEN(VLS)) uut_small (
    .clk(clk), .rst(rst), .we(1'b0), .eew(s_eew), .lmul_pow(3'd0),
    .vrid(5'd0), .index(s_index), .wdata(64'd0), .rdata(s_rdata),
    .group_error(s_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int e, input int lp, input int vr, input int idx,
                       input bit w, input logic [63:0] d);
    @(negedge clk);
    eew      = 2'(e);
    lmul_pow = 3'(lp);
    vrid     = 5'(vr);
    index    = IW'(idx);
    we       = w;
    wdata    = d;
    #1;
  endtask

  task automatic check_reg(input int r, input string req);
    drive(3, 0, r, 0, 1'b0, 64'd0);
    check(rdata == model[r][63:0], req, "low half", rdata, model[r][63:0]);
    drive(3, 0, r, 1, 1'b0, 64'd0);
    check(rdata == model[r][127:64], req, "high half", rdata, model[r][127:64]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual cycles %0d expected below %0d", 190000, 190000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt = 0;
    for (int r = 0; r < 32; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: every register reads zero after reset
    for (int r = 0; r < 32; r++) check_reg(r, "R9");

    // R6: element wider than a 32-bit register is illegal
    @(negedge clk);
    s_eew = 2'd3; s_index = '0;
    #1;
    check(s_err == 1'b1, "R6", "64-bit element in 32-bit reg", 64'(s_err), 64'd1);
    check(s_rdata == 64'd0, "R6", "rdata on wide element", s_rdata, 64'd0);
    @(negedge clk);
    s_eew = 2'd2;
    #1;
    check(s_err == 1'b0, "R6", "32-bit element in 32-bit reg", 64'(s_err), 64'd0);

    // sweep every width, exponent and base register
    for (int lp = -1; lp <= 3; lp++) begin
      for (int e = 0; e < 4; e++) begin
        for (int vr = 0; vr < 32; vr++) begin
          int ew, epr, grp, lpr;
          int cand [6];
          ew  = 8 << e;
          epr = VL / ew;
          lpr = (lp < 0) ? 0 : lp;
          grp = 1 << lpr;
          cand[0] = 0;
          cand[1] = epr - 1;
          cand[2] = epr;
          cand[3] = grp * epr - 1;
          cand[4] = grp * epr;
          cand[5] = (grp * epr) / 2 + 1;
          for (int k = 0; k < 6; k++) begin
            int idx, rig, preg, off;
            bit ovf, mis, outg, err;
            logic [63:0] msk, pat, exp_rd;
            string tag;
            idx = cand[k];
            if (idx > (1 << IW) - 1) continue;
            cnt++;
            rig  = idx / epr;
            preg = vr + rig;
            off  = (idx % epr) * ew;
            ovf  = (vr + grp) > 32;
            mis  = (vr % grp) != 0;
            outg = rig >= grp;
            err  = ovf | mis | outg;
            msk  = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
            pat  = {32'(cnt * 32'h9E3779B1), 32'(~cnt * 32'h85EBCA6B)};
            if (ovf) tag = "R3";
            else if (mis) tag = "R4";
            else if (outg) tag = "R5";
            else if (lp < 0) tag = "R2";
            else tag = "R1";
            drive(e, lp, vr, idx, 1'b1, pat);
            check(group_error == err, tag, "group_error", 64'(group_error), 64'(err));
            if (err) begin
              exp_rd = 64'd0;
              check(rdata == exp_rd, "R8", "rdata on illegal", rdata, exp_rd);
            end else begin
              exp_rd = 64'(model[preg] >> off) & msk;
              check(rdata == exp_rd, tag, "element read", rdata, exp_rd);
              model[preg] = (model[preg] & ~(VL'(msk) << off)) | (VL'(pat & msk) << off);
            end
            // R7 / R8: whole register contents after the edge
            if (err) check_reg((preg < 32) ? preg : vr, "R8");
            else check_reg(preg, "R7");
          end
        end
      end
    end

    // R9: reset in mid-run clears written contents
    @(negedge clk);
    we = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 32; r++) model[r] = '0;
    for (int r = 0; r < 32; r += 5) check_reg(r, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule